// File: doc/BRIEF.md
# Stream Prefetch Engine

This block keeps a small table of active data streams and, for each one, runs a fixed number of cache lines ahead of the program's demand accesses. It issues prefetch requests for those lines. A stride detector outside the block opens streams by handing over a base line and a stride. Demand misses that land on a stream's next expected line move that stream forward, and the engine then tops up its lead again. All addresses are cache-line addresses of 64-byte lines.

A five-bit control word sets how aggressive the engine is:

- The low three bits select the prefetch depth. One value switches the engine off, and another picks a built-in default.
- One bit lets store misses take part.
- One bit allows strides other than one line.

Each line is fetched twice, in order. The first request fills the last-level cache and the second fills the near data cache. A single depth setting governs both. Streams never run past the end of the 64 KB page they started in.

Requests leave one per cycle on a valid/ready pair. The request presented is re-evaluated every cycle, and a transfer happens only in a cycle where both valid and ready are high.

Top module: `stream_prefetch_engine`

## Requirements
- R1: At most NUM_STREAMS (default 12) streams are held. When every entry is valid, an accepted allocation replaces the entry least recently allocated or advanced by a demand miss.
- R2: ctrl_word[2:0] = 3'b001 turns the engine off. In that state pf_valid stays low, and both allocations and demand misses are ignored, so no stream exists or moves afterwards.
- R3: ctrl_word[2:0] = 3'b000 selects a depth of 5 lines. Codes 3'b010 to 3'b111 select depths 2 to 7. A stream stops issuing once that many lines lie ahead of its next expected demand line.
- R4: ctrl_word[3] = 0 makes store traffic inert. An allocation with alloc_is_store = 1 is ignored, and a miss with miss_is_store = 1 advances no stream. With the bit set, both act like loads.
- R5: ctrl_word[4] = 0 causes an allocation with a stride other than 1 to be ignored. An allocation with stride 0 is always ignored.
- R6: A page is 1024 lines (64 KB), and the page number is line[LINE_AW-1:10]. An allocation whose first line leaves the page of its base is ignored. A stream issues nothing beyond the last line of its page, and it closes when its next expected line would leave the page.
- R7: Every prefetched line is presented first with pf_to_llc = 1 (last-level fill) and then with pf_to_llc = 0 (near fill). The stream moves on to its next line only after both have transferred.
- R8: A stream allocated with base b and stride s expects demand line b+s next. It prefetches the lines b+s, b+2s, and so on, skipping the lines in between when s > 1.
- R9: A miss on a stream's next expected line advances that expectation by s and restores the stream's lead to the full depth. A miss on any other line has no effect.
- R10: At most one request transfers per cycle, and only when pf_valid and pf_ready are both high. While pf_ready is low the pending request stays presented. The lowest-numbered stream with work is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 5 | Aggressiveness control: [2:0] depth code, [3] store enable, [4] stride enable |
| miss_valid | input | 1 | A demand miss is reported this cycle |
| miss_line | input | LINE_AW | Line address of the demand miss |
| miss_is_store | input | 1 | The miss came from a store |
| alloc_valid | input | 1 | Stride detector requests a new stream |
| alloc_line | input | LINE_AW | Base line of the new stream (already demanded) |
| alloc_stride | input | STRIDE_W | Stream stride in lines |
| alloc_is_store | input | 1 | The new stream was detected on stores |
| pf_valid | output | 1 | A prefetch request is presented |
| pf_ready | input | 1 | Downstream accepts the presented request |
| pf_line | output | LINE_AW | Line address to prefetch |
| pf_to_llc | output | 1 | 1: fill the last-level cache, 0: fill the near data cache |

## Verification
The bench drives several kinds of streams:

- Unit-stride streams at each boundary depth code separate the default, shallowest and deepest leads.
- A stride-4 stream shows whether non-adjacent lines are skipped and whether the stride gate holds.
- A stream based just below a page end shows where issue stops.
- A matching versus a non-matching miss, and a store versus a load miss, distinguish real advancement from spurious top-ups.
- Filling all twelve entries and then touching one before a thirteenth allocation tells least-recently-used replacement apart from simple rotation.

Holding pf_ready low shows that a request is kept until it is taken.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

   // decoded view of the five-bit control word
   typedef struct packed {
      logic       on;
      logic [2:0] depth;
      logic       store_en;
      logic       stride_en;
   } pfe_cfg_t;

   localparam logic [2:0] CODE_DEFAULT = 3'b000;
   localparam logic [2:0] CODE_OFF     = 3'b001;

   function automatic pfe_cfg_t pfe_decode(input logic [4:0] w, input logic [2:0] dflt);
      pfe_cfg_t c;
      c.on        = (w[2:0] != CODE_OFF);
      c.depth     = (w[2:0] == CODE_DEFAULT) ? dflt :
                    (w[2:0] == CODE_OFF)     ? 3'd0 : w[2:0];
      c.store_en  = w[3];
      c.stride_en = w[4];
      return c;
   endfunction

endpackage

// File: rtl/pfe_stream_slot.sv
module pfe_stream_slot #(
   parameter int LINE_AW        = 26,
   parameter int PAGE_LINE_BITS = 10,
   parameter int STRIDE_W       = 8,
   parameter int CNT_W          = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       alloc_i,
   input  logic [LINE_AW-1:0]         alloc_first_i,
   input  logic [LINE_AW-PAGE_LINE_BITS-1:0] alloc_page_i,
   input  logic [STRIDE_W-1:0]        alloc_stride_i,
   input  logic                       demand_i,
   input  logic [LINE_AW-1:0]         demand_line_i,
   input  logic [CNT_W-1:0]           depth_i,
   input  logic                       issue_done_i,
   output logic                       valid_o,
   output logic                       hit_o,
   output logic                       req_o,
   output logic [LINE_AW-1:0]         line_o,
   output logic                       llc_o
);
   localparam int PG_W = LINE_AW - PAGE_LINE_BITS;

   logic                vld_q, half_q, end_q;
   logic [STRIDE_W-1:0] stride_q;
   logic [PG_W-1:0]     pg_q;
   logic [LINE_AW-1:0]  nd_q, ip_q;
   logic [CNT_W-1:0]    ahead_q, ahead_d;

   logic [LINE_AW:0] stride_ext, nd_sum, ip_sum;
   logic nd_leaves, ip_leaves, hit, full_done, jump, consume;

   assign stride_ext = {{(LINE_AW+1-STRIDE_W){1'b0}}, stride_q};
   assign nd_sum     = {1'b0, nd_q} + stride_ext;
   assign ip_sum     = {1'b0, ip_q} + stride_ext;
   assign nd_leaves  = nd_sum[LINE_AW] || (nd_sum[LINE_AW-1:PAGE_LINE_BITS] != pg_q);
   assign ip_leaves  = ip_sum[LINE_AW] || (ip_sum[LINE_AW-1:PAGE_LINE_BITS] != pg_q);

   assign hit       = vld_q && demand_i && (demand_line_i == nd_q);
   assign full_done = issue_done_i && half_q;
   assign jump      = hit && (ahead_q == '0) && !full_done;
   assign consume   = hit && ((ahead_q != '0) || full_done);

   always_comb begin
      ahead_d = ahead_q;
      if (full_done && !consume)      ahead_d = ahead_q + CNT_W'(1);
      else if (!full_done && consume) ahead_d = ahead_q - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;  half_q <= 1'b0;  end_q <= 1'b0;
         stride_q <= '0; pg_q <= '0; nd_q <= '0; ip_q <= '0; ahead_q <= '0;
      end else if (alloc_i) begin
         vld_q    <= 1'b1;
         stride_q <= alloc_stride_i;
         pg_q     <= alloc_page_i;
         nd_q     <= alloc_first_i;
         ip_q     <= alloc_first_i;
         ahead_q  <= '0;
         half_q   <= 1'b0;
         end_q    <= 1'b0;
      end else begin
         if (hit && nd_leaves) vld_q <= 1'b0;
         if (hit) nd_q <= nd_sum[LINE_AW-1:0];
         if (full_done) begin
            ip_q  <= ip_sum[LINE_AW-1:0];
            end_q <= ip_leaves;
         end else if (jump) begin
            ip_q  <= nd_sum[LINE_AW-1:0];
            end_q <= 1'b0;
         end
         if (full_done || jump) half_q <= 1'b0;
         else if (issue_done_i) half_q <= 1'b1;
         ahead_q <= ahead_d;
      end
   end

   assign valid_o = vld_q;
   assign hit_o   = hit;
   assign req_o   = vld_q && !end_q && (ahead_q < depth_i);
   assign line_o  = ip_q;
   assign llc_o   = !half_q;
endmodule

// File: rtl/pfe_lru.sv
module pfe_lru #(
   parameter int NUM   = 12,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_i,
   input  logic [IDX_W-1:0] touch_idx_i,
   input  logic [NUM-1:0]   valid_i,
   output logic [IDX_W-1:0] victim_o
);
   // rank 0 = most recent, NUM-1 = least recent; ranks form a permutation
   logic [NUM-1:0][IDX_W-1:0] rank_q;
   logic [IDX_W-1:0]          touched_rank;

   assign touched_rank = rank_q[touch_idx_i];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM; i++) rank_q[i] <= IDX_W'(i);
      end else if (touch_i) begin
         for (int i = 0; i < NUM; i++) begin
            if (IDX_W'(i) == touch_idx_i)      rank_q[i] <= '0;
            else if (rank_q[i] < touched_rank) rank_q[i] <= rank_q[i] + IDX_W'(1);
         end
      end
   end

   always_comb begin
      logic found;
      found    = 1'b0;
      victim_o = '0;
      for (int i = NUM-1; i >= 0; i--) begin
         if (!valid_i[i]) begin
            victim_o = IDX_W'(i);
            found    = 1'b1;
         end
      end
      if (!found) begin
         for (int i = 0; i < NUM; i++)
            if (rank_q[i] == IDX_W'(NUM-1)) victim_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/pfe_issue_arb.sv
module pfe_issue_arb #(
   parameter int NUM   = 12,
   parameter int IDX_W = 4
) (
   input  logic [NUM-1:0]   req_i,
   output logic [NUM-1:0]   grant_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);
   always_comb begin
      idx_o = '0;
      for (int i = NUM-1; i >= 0; i--)
         if (req_i[i]) idx_o = IDX_W'(i);
      any_o   = |req_i;
      grant_o = '0;
      for (int i = 0; i < NUM; i++)
         grant_o[i] = any_o && (idx_o == IDX_W'(i));
   end
endmodule

// File: rtl/stream_prefetch_engine.sv
module stream_prefetch_engine
   import pfe_pkg::*;
#(
   parameter int NUM_STREAMS    = 12,
   parameter int LINE_AW        = 26,
   parameter int PAGE_LINE_BITS = 10,
   parameter int STRIDE_W       = 8,
   parameter int DEFAULT_DEPTH  = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [4:0]          ctrl_word,
   input  logic                miss_valid,
   input  logic [LINE_AW-1:0]  miss_line,
   input  logic                miss_is_store,
   input  logic                alloc_valid,
   input  logic [LINE_AW-1:0]  alloc_line,
   input  logic [STRIDE_W-1:0] alloc_stride,
   input  logic                alloc_is_store,
   output logic                pf_valid,
   input  logic                pf_ready,
   output logic [LINE_AW-1:0]  pf_line,
   output logic                pf_to_llc
);
   localparam int IDX_W = $clog2(NUM_STREAMS);
   localparam int PG_W  = LINE_AW - PAGE_LINE_BITS;
   localparam int CNT_W = 3;

   if (NUM_STREAMS < 2) begin : g_bad_num
      $error("NUM_STREAMS must be at least 2");
   end
   if (STRIDE_W >= PAGE_LINE_BITS || PAGE_LINE_BITS >= LINE_AW) begin : g_bad_width
      $error("need STRIDE_W < PAGE_LINE_BITS < LINE_AW");
   end
   if (DEFAULT_DEPTH < 2 || DEFAULT_DEPTH > 7) begin : g_bad_depth
      $error("DEFAULT_DEPTH must lie in 2..7");
   end

   pfe_cfg_t cfg;
   assign cfg = pfe_decode(ctrl_word, 3'(DEFAULT_DEPTH));

   // qualified miss and allocation
   logic miss_ok, alloc_ok, alloc_in_page;
   logic [LINE_AW:0] alloc_sum;
   assign alloc_sum     = {1'b0, alloc_line} + {{(LINE_AW+1-STRIDE_W){1'b0}}, alloc_stride};
   assign alloc_in_page = !alloc_sum[LINE_AW] &&
                          (alloc_sum[LINE_AW-1:PAGE_LINE_BITS] == alloc_line[LINE_AW-1:PAGE_LINE_BITS]);
   assign miss_ok  = miss_valid && cfg.on && (!miss_is_store || cfg.store_en);
   assign alloc_ok = alloc_valid && cfg.on && alloc_in_page && (alloc_stride != '0) &&
                     ((alloc_stride == STRIDE_W'(1)) || cfg.stride_en) &&
                     (!alloc_is_store || cfg.store_en);

   logic [NUM_STREAMS-1:0] slot_valid, slot_hit, slot_req, slot_llc, grant;
   logic [LINE_AW-1:0]     slot_line [NUM_STREAMS];
   logic [IDX_W-1:0]       victim, hit_idx, sel_idx;
   logic                   hit_any, touch;

   always_comb begin
      hit_idx = '0;
      hit_any = |slot_hit;
      for (int i = NUM_STREAMS-1; i >= 0; i--)
         if (slot_hit[i]) hit_idx = IDX_W'(i);
   end
   assign touch = alloc_ok || hit_any;

   pfe_lru #(.NUM(NUM_STREAMS), .IDX_W(IDX_W)) i_lru (
      .clk(clk), .rst_n(rst_n), .touch_i(touch),
      .touch_idx_i(alloc_ok ? victim : hit_idx),
      .valid_i(slot_valid), .victim_o(victim)
   );

   for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_slot
      pfe_stream_slot #(
         .LINE_AW(LINE_AW), .PAGE_LINE_BITS(PAGE_LINE_BITS),
         .STRIDE_W(STRIDE_W), .CNT_W(CNT_W)
      ) i_slot (
         .clk(clk), .rst_n(rst_n),
         .alloc_i(alloc_ok && (victim == IDX_W'(g))),
         .alloc_first_i(alloc_sum[LINE_AW-1:0]),
         .alloc_page_i(alloc_line[LINE_AW-1:PAGE_LINE_BITS]),
         .alloc_stride_i(alloc_stride),
         .demand_i(miss_ok), .demand_line_i(miss_line),
         .depth_i(cfg.depth),
         .issue_done_i(grant[g] && pf_ready),
         .valid_o(slot_valid[g]), .hit_o(slot_hit[g]), .req_o(slot_req[g]),
         .line_o(slot_line[g]), .llc_o(slot_llc[g])
      );
   end

   pfe_issue_arb #(.NUM(NUM_STREAMS), .IDX_W(IDX_W)) i_arb (
      .req_i(slot_req), .grant_o(grant), .idx_o(sel_idx), .any_o(pf_valid)
   );

   assign pf_line   = slot_line[sel_idx];
   assign pf_to_llc = slot_llc[sel_idx];

   logic [PG_W-1:0] unused_pg;
   assign unused_pg = '0;
endmodule

// File: rtl/stream_prefetch_engine_chk.sv
module stream_prefetch_engine_chk #(
   parameter int NUM_STREAMS = 12,
   parameter int STRIDE_W    = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [4:0]             ctrl_word,
   input logic                   alloc_valid,
   input logic [STRIDE_W-1:0]    alloc_stride,
   input logic                   alloc_is_store,
   input logic                   pf_valid,
   input logic [NUM_STREAMS-1:0] slot_valid,
   input logic [NUM_STREAMS-1:0] grant
);
   // R2: the engine presents nothing while switched off
   a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[2:0] == 3'b001) |-> !pf_valid);

   // R2: no stream is opened while switched off
   a_r2_off_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && ctrl_word[2:0] == 3'b001)
      |=> ($countones(slot_valid) <= $past($countones(slot_valid))));

   // R4: store allocations are dropped with the store bit clear
   a_r4_store_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && alloc_is_store && !ctrl_word[3])
      |=> ($countones(slot_valid) <= $past($countones(slot_valid))));

   // R5: non-unit strides are dropped with the stride bit clear
   a_r5_stride_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && alloc_stride != STRIDE_W'(1) && !ctrl_word[4])
      |=> ($countones(slot_valid) <= $past($countones(slot_valid))));

   // R10: a single stream is served per cycle, and only when one is presented
   a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (pf_valid == (grant != '0)));
endmodule

bind stream_prefetch_engine stream_prefetch_engine_chk #(
   .NUM_STREAMS(NUM_STREAMS), .STRIDE_W(STRIDE_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
   .alloc_valid(alloc_valid), .alloc_stride(alloc_stride),
   .alloc_is_store(alloc_is_store), .pf_valid(pf_valid),
   .slot_valid(slot_valid), .grant(grant)
);

// File: tb/test_stream_prefetch_engine.sv
module test_stream_prefetch_engine;
   localparam int LAW = 26;
   localparam int SW  = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic           rst_n = 1'b0;
   logic [4:0]     ctrl = 5'b00000;
   logic           miss_valid = 1'b0, miss_is_store = 1'b0;
   logic [LAW-1:0] miss_line = '0;
   logic           alloc_valid = 1'b0, alloc_is_store = 1'b0;
   logic [LAW-1:0] alloc_line = '0;
   logic [SW-1:0]  alloc_stride = '0;
   logic           pf_valid, pf_to_llc;
   logic           pf_ready = 1'b1;
   logic [LAW-1:0] pf_line;

   stream_prefetch_engine i_stream_prefetch_engine (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl),
      .miss_valid(miss_valid), .miss_line(miss_line), .miss_is_store(miss_is_store),
      .alloc_valid(alloc_valid), .alloc_line(alloc_line),
      .alloc_stride(alloc_stride), .alloc_is_store(alloc_is_store),
      .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line), .pf_to_llc(pf_to_llc)
   );

   typedef struct packed { logic llc; logic [LAW-1:0] line; } exp_t;
   exp_t  sb[$];
   int    checks = 0, errors = 0;
   string tag = "R10";

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: every transfer is compared with the scoreboard head (R7, R8)
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && pf_valid && pf_ready) begin
         if (sb.size() == 0) check(1'b0, tag, "unexpected request", {pf_to_llc, pf_line}, 0);
         else begin
            e = sb.pop_front();
            check({pf_to_llc, pf_line} == e, tag, "request {llc,line}", {pf_to_llc, pf_line}, e);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(1);
   endtask

   task automatic do_alloc(input logic [LAW-1:0] b, input logic [SW-1:0] s, input bit st);
      @(posedge clk); #1;
      alloc_valid = 1'b1; alloc_line = b; alloc_stride = s; alloc_is_store = st;
      @(posedge clk); #1;
      alloc_valid = 1'b0;
   endtask

   task automatic do_miss(input logic [LAW-1:0] l, input bit st);
      @(posedge clk); #1;
      miss_valid = 1'b1; miss_line = l; miss_is_store = st;
      @(posedge clk); #1;
      miss_valid = 1'b0;
   endtask

   task automatic expect_lines(input logic [LAW-1:0] first, input int s, input int n);
      for (int i = 0; i < n; i++) begin
         sb.push_back({1'b1, first + LAW'(i*s)});
         sb.push_back({1'b0, first + LAW'(i*s)});
      end
   endtask

   task automatic drained(input string what);
      cyc(40);
      check(sb.size() == 0, tag, {what, ": outstanding expected"}, sb.size(), 0);
      check(!pf_valid, tag, {what, ": engine idle"}, pf_valid, 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      do_reset();
      check(!pf_valid, "R10", "reset pf_valid", pf_valid, 0);

      // R3 R8 R7: default depth code gives five lines
      tag = "R3"; ctrl = 5'b00000;
      expect_lines(26'h101, 1, 5);
      do_alloc(26'h100, 1, 0);
      drained("default depth");

      // R9: matching misses top up one line each; a stray miss does nothing
      tag = "R9";
      expect_lines(26'h106, 1, 1);
      do_miss(26'h101, 0);
      drained("first top-up");
      do_miss(26'h150, 0);
      drained("stray miss");
      expect_lines(26'h107, 1, 1);
      do_miss(26'h102, 0);
      drained("second top-up");

      // R3: shallowest and deepest codes
      do_reset(); tag = "R3"; ctrl = 5'b00010;
      expect_lines(26'h201, 1, 2);
      do_alloc(26'h200, 1, 0);
      drained("depth 2");
      do_reset(); ctrl = 5'b00111;
      expect_lines(26'h701, 1, 7);
      do_alloc(26'h700, 1, 0);
      drained("depth 7");

      // R2: off code ignores allocation, nothing shows after turning on
      do_reset(); tag = "R2"; ctrl = 5'b00001;
      do_alloc(26'h500, 1, 0);
      drained("off alloc");
      ctrl = 5'b00010;
      drained("off then on");

      // R5: stride gate, then strided stream and strided advance (R8, R9)
      do_reset(); tag = "R5"; ctrl = 5'b00010;
      do_alloc(26'h300, 4, 0);
      drained("stride gated");
      do_alloc(26'h300, 0, 0);
      drained("stride zero");
      ctrl = 5'b10010; tag = "R8";
      expect_lines(26'h304, 4, 2);
      do_alloc(26'h300, 4, 0);
      drained("stride 4");
      tag = "R9";
      expect_lines(26'h30C, 4, 1);
      do_miss(26'h304, 0);
      drained("stride advance");

      // R4: store gating
      do_reset(); tag = "R4"; ctrl = 5'b00010;
      do_alloc(26'h480, 1, 1);
      drained("store alloc gated");
      expect_lines(26'h401, 1, 2);
      do_alloc(26'h400, 1, 0);
      drained("load stream");
      do_miss(26'h401, 1);
      drained("store miss gated");
      ctrl = 5'b01010;
      expect_lines(26'h403, 1, 1);
      do_miss(26'h401, 1);
      drained("store miss enabled");

      // R6: page boundary
      do_reset(); tag = "R6"; ctrl = 5'b00111;
      do_alloc(26'h7FF, 1, 0);
      drained("alloc leaving page");
      expect_lines(26'h7FD, 1, 3);
      do_alloc(26'h7FC, 1, 0);
      drained("issue stops at page end");

      // R10: backpressure holds the first request
      do_reset(); tag = "R10"; ctrl = 5'b00010; pf_ready = 1'b0;
      do_alloc(26'h600, 1, 0);
      cyc(5);
      check(pf_valid && pf_to_llc && pf_line == 26'h601, "R10", "held request",
            {pf_valid, pf_to_llc, pf_line}, {2'b11, 26'h601});
      expect_lines(26'h601, 1, 2);
      pf_ready = 1'b1;
      drained("after release");

      // R1: fill all entries, touch entry 0, a new stream replaces entry 1
      do_reset(); tag = "R1"; ctrl = 5'b00010;
      for (int k = 0; k < 12; k++) begin
         expect_lines(LAW'(k*1024 + 16 + 1), 1, 2);
         do_alloc(LAW'(k*1024 + 16), 1, 0);
         drained("fill");
      end
      expect_lines(26'h13, 1, 1);
      do_miss(26'h11, 0);
      drained("touch entry 0");
      expect_lines(26'h20001, 1, 2);
      do_alloc(26'h20000, 1, 0);
      drained("thirteenth stream");
      do_miss(LAW'(1024 + 17), 0);
      drained("replaced stream silent");
      expect_lines(26'h14, 1, 1);
      do_miss(26'h12, 0);
      drained("kept stream alive");

      finish_run();
   end
endmodule